// File: doc/BRIEF.md
# Serial Display Link Framer

This block sends one byte at a time to a character display controller over a three-wire synchronous serial link. The link has an active-low select, a serial clock and a serial data output. A requester offers a byte and a flag that marks it as data or as a command, using a valid/ready handshake. The block then builds a 24-bit frame and shifts it out. The frame is a sync byte followed by the payload, which is split into two nibbles, and each nibble is padded with zeros.

The serial clock half-period is a parameter counted in system clock cycles. Data changes only while the serial clock is low, so the display samples each bit on the rising clock edge. When a frame ends, a programmable hold-off keeps the block busy, so a slow display controller can finish the command before the next byte arrives. A one-cycle done pulse marks the point where the block can accept again.

Top module: `disp_frame_tx`

## Requirements
- R1: While reset is held and right after it, select is high, the serial clock is high, serial data is low, ready is high and done is low.
- R2: Each frame opens with an 8-bit sync word sent most significant bit first: 0xF8 when the flag marks a command (flag 0) and 0xFA when it marks data (flag 1).
- R3: After the sync word, payload bits 0, 1, 2 and 3 follow in that order, then four zero bits.
- R4: After the first padding group, payload bits 4, 5, 6 and 7 follow in that order, then four zero bits that close the frame.
- R5: While select is low for one frame, exactly 24 rising serial clock edges occur.
- R6: Select falls in the cycle after acceptance. The serial clock stays high for HALF_CYC cycles before its first fall. Select rises in the cycle after the last high phase ends.
- R7: While select is low and the serial clock is high, serial data does not change. Each new bit appears together with the falling clock.
- R8: Every low phase and every high phase of the serial clock lasts exactly HALF_CYC system cycles.
- R9: After select rises, ready stays low for HOLD_CYC more cycles.
- R10: Ready is low from the cycle after acceptance until the frame and the hold-off have both completed. A valid request offered while ready is low has no effect on the link.
- R11: Done is high for exactly one cycle. It appears in the same cycle that ready returns high.
- R12: Whenever select is high, the serial clock is high and serial data is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request offers a byte |
| in_ready | output | 1 | Block can accept a byte this cycle |
| in_is_data | input | 1 | 1 = data byte, 0 = command byte |
| in_byte | input | 8 | Payload byte |
| done | output | 1 | One-cycle pulse at end of frame plus hold-off |
| lnk_sel_n | output | 1 | Active-low link select |
| lnk_sclk | output | 1 | Serial clock |
| lnk_sdo | output | 1 | Serial data out |

## Verification
A request is accepted at a rising edge where valid and ready are both high. Every link output and ready then change starting in the next cycle, and each of these results has a fixed cycle within the frame. With H the half-period and D the hold-off, select is low for 49·H cycles. The hold-off then runs for D cycles, and done and ready appear in cycle 49·H+D+1. A reference model in the bench sees each acceptance at the clock edge and queues one expected tuple of select, clock, data, ready and done for every following cycle. It compares the design outputs on each falling edge against the head of that queue, or against the idle tuple when the queue is empty. A second observer rebuilds every frame from the rising edges of the serial clock and checks the sync word, the nibbles and the bit count.

// File: rtl/dsl_pkg.sv
package dsl_pkg;

    localparam int FRAME_BITS = 24;
    localparam logic [7:0] SYNC_CMD = 8'hF8;
    localparam logic [7:0] SYNC_DAT = 8'hFA;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_HOLD
    } dsl_state_e;

    typedef struct packed {
        logic       is_data;
        logic [7:0] payload;
    } dsl_req_t;

    typedef struct packed {
        logic sel_n;
        logic sclk;
        logic sdo;
    } dsl_pins_t;

    localparam dsl_pins_t PINS_IDLE = '{sel_n: 1'b1, sclk: 1'b1, sdo: 1'b0};

    // Nibble in wire order: bit 0 goes out first, so it lands in the top position.
    function automatic logic [3:0] nib_wire(input logic [3:0] n);
        return {n[0], n[1], n[2], n[3]};
    endfunction

    // Whole frame; bit FRAME_BITS-1 is the first bit on the wire.
    function automatic logic [FRAME_BITS-1:0] build_frame(input dsl_req_t r);
        logic [7:0] sync;
        sync = r.is_data ? SYNC_DAT : SYNC_CMD;
        return {sync,
                nib_wire(r.payload[3:0]), 4'b0000,
                nib_wire(r.payload[7:4]), 4'b0000};
    endfunction

endpackage

// File: rtl/dsl_half_timer.sv
module dsl_half_timer #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic span_end
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] cnt;

    assign span_end = run && (cnt == CW'(HALF_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || span_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8
    span_from_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> (cnt == '0));

endmodule

// File: rtl/dsl_frame_shreg.sv
module dsl_frame_shreg #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] frame_in,
    input  logic         take,
    output logic         head,
    output logic         all_taken
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  sreg;
    logic [CW-1:0] taken;

    assign head      = sreg[W-1];
    assign all_taken = (taken == CW'(W));

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg  <= '0;
            taken <= '0;
        end else if (load) begin
            sreg  <= frame_in;
            taken <= '0;
        end else if (take) begin
            sreg  <= {sreg[W-2:0], 1'b0};
            taken <= taken + 1'b1;
        end
    end

    // R5
    take_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> !all_taken);

    // R5
    no_load_and_take_chk: assert property (@(posedge clk) disable iff (rst)
        !(load && take));

endmodule

// File: rtl/dsl_holdoff.sv
module dsl_holdoff #(
    parameter int HOLD_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic expire
);
    generate
        if (HOLD_CYC == 0) begin : g_none
            assign expire = active;
        end else begin : g_cnt
            localparam int HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
            logic [HW-1:0] cnt;

            assign expire = active && (cnt == HW'(HOLD_CYC - 1));

            always_ff @(posedge clk) begin
                if (rst || !active || expire) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            // R9
            hold_from_zero_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(active) |-> (cnt == '0));
        end
    endgenerate

endmodule

// File: rtl/disp_frame_tx.sv
module disp_frame_tx #(
    parameter int HALF_CYC = 4,
    parameter int HOLD_CYC = 1000000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       in_is_data,
    input  logic [7:0] in_byte,
    output logic       done,
    output logic       lnk_sel_n,
    output logic       lnk_sclk,
    output logic       lnk_sdo
);
    import dsl_pkg::*;

    dsl_state_e st;
    dsl_pins_t  pins;
    dsl_req_t   req;
    logic       phase_hi;
    logic       done_q;

    logic run, span_end, load, take, head, all_taken, hold_act, expire;
    logic [FRAME_BITS-1:0] frame;

    assign req      = '{is_data: in_is_data, payload: in_byte};
    assign frame    = build_frame(req);
    assign in_ready = (st == ST_IDLE);
    assign load     = in_ready && in_valid;
    assign run      = (st == ST_LEAD) || (st == ST_SHIFT);
    assign hold_act = (st == ST_HOLD);
    assign take     = span_end &&
                      ((st == ST_LEAD) || (st == ST_SHIFT && phase_hi && !all_taken));

    dsl_half_timer #(.HALF_CYC(HALF_CYC)) u_half (
        .clk(clk), .rst(rst), .run(run), .span_end(span_end)
    );

    dsl_frame_shreg #(.W(FRAME_BITS)) u_shreg (
        .clk(clk), .rst(rst), .load(load), .frame_in(frame), .take(take),
        .head(head), .all_taken(all_taken)
    );

    dsl_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk(clk), .rst(rst), .active(hold_act), .expire(expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            pins     <= PINS_IDLE;
            phase_hi <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (in_valid) begin
                        st         <= ST_LEAD;
                        pins.sel_n <= 1'b0;
                    end
                end
                ST_LEAD: begin
                    if (span_end) begin
                        st        <= ST_SHIFT;
                        pins.sclk <= 1'b0;
                        pins.sdo  <= head;
                        phase_hi  <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (span_end) begin
                        if (!phase_hi) begin
                            pins.sclk <= 1'b1;
                            phase_hi  <= 1'b1;
                        end else if (all_taken) begin
                            pins <= PINS_IDLE;
                            if (HOLD_CYC == 0) begin
                                st     <= ST_IDLE;
                                done_q <= 1'b1;
                            end else begin
                                st <= ST_HOLD;
                            end
                        end else begin
                            pins.sclk <= 1'b0;
                            pins.sdo  <= head;
                            phase_hi  <= 1'b0;
                        end
                    end
                end
                ST_HOLD: begin
                    if (expire) begin
                        st     <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign lnk_sel_n = pins.sel_n;
    assign lnk_sclk  = pins.sclk;
    assign lnk_sdo   = pins.sdo;
    assign done      = done_q;

    // R12
    idle_clk_high_chk: assert property (@(posedge clk) disable iff (rst)
        lnk_sel_n |-> lnk_sclk);

    // R12
    idle_sdo_low_chk: assert property (@(posedge clk) disable iff (rst)
        lnk_sel_n |-> !lnk_sdo);

    // R7
    data_steady_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!lnk_sel_n && $past(!lnk_sel_n) && lnk_sclk) |-> $stable(lnk_sdo));

    // R6
    sel_fall_clk_high_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lnk_sel_n) |-> lnk_sclk);

    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !lnk_sel_n |-> !in_ready);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    done_with_ready_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> in_ready);

    generate
        if (HOLD_CYC > 0) begin : g_hold_chk
            // R9
            hold_gap_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(lnk_sel_n) |-> !in_ready);
        end
    endgenerate

endmodule

// File: tb/test_disp_frame_tx.sv
module test_disp_frame_tx;

    localparam int H = 3;
    localparam int D = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_is_data = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ready, done, lnk_sel_n, lnk_sclk, lnk_sdo;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    disp_frame_tx #(.HALF_CYC(H), .HOLD_CYC(D)) i_disp_frame_tx (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_is_data(in_is_data), .in_byte(in_byte), .done(done),
        .lnk_sel_n(lnk_sel_n), .lnk_sclk(lnk_sclk), .lnk_sdo(lnk_sdo)
    );

    // Stream bit i of a frame, built from the requirements (R2, R3, R4).
    function automatic logic stream_bit(input logic isd, input logic [7:0] b, input int i);
        logic [7:0] sync;
        sync = isd ? 8'hFA : 8'hF8;
        if (i < 8)       return sync[7-i];
        else if (i < 12) return b[i-8];
        else if (i < 16) return 1'b0;
        else if (i < 20) return b[i-16+4];
        else             return 1'b0;
    endfunction

    // Reference model: tuple {sel_n, sclk, sdo, ready, done} per cycle.
    logic [4:0] exp_q[$];
    logic [8:0] byte_q[$];
    logic       exp_ready_now = 1'b1;

    always @(posedge clk) begin
        if (!rst && in_valid && exp_ready_now) begin
            byte_q.push_back({in_is_data, in_byte});
            for (int k = 0; k < H; k++) exp_q.push_back(5'b01000);
            for (int i = 0; i < 24; i++) begin
                logic b;
                b = stream_bit(in_is_data, in_byte, i);
                for (int k = 0; k < H; k++) exp_q.push_back({2'b00, b, 2'b00});
                for (int k = 0; k < H; k++) exp_q.push_back({2'b01, b, 2'b00});
            end
            for (int k = 0; k < D; k++) exp_q.push_back(5'b11000);
            exp_q.push_back(5'b11011);
        end
    end

    always @(negedge clk) begin
        logic [4:0] e, a;
        if (rst) begin
            exp_ready_now = 1'b1;
        end else begin
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 5'b11010;
            a = {lnk_sel_n, lnk_sclk, lnk_sdo, in_ready, done};
            exp_ready_now = e[1];
            checks++;
            if (a !== e) begin
                errors++;
                if (a[4] !== e[4])
                    $display("FAIL R6 select act=%b exp=%b", a[4], e[4]);
                else if (a[3] !== e[3])
                    $display("FAIL R8 sclk act=%b exp=%b", a[3], e[3]);
                else if (a[2] !== e[2])
                    $display("FAIL R7 sdo act=%b exp=%b", a[2], e[2]);
                else if (a[1] !== e[1])
                    $display("FAIL R10 ready act=%b exp=%b", a[1], e[1]);
                else
                    $display("FAIL R11 done act=%b exp=%b", a[0], e[0]);
            end
        end
    end

    // Frame rebuild from the link lines.
    logic cap[24];
    int   nbits = 0;
    bit   framing = 0;

    always @(negedge lnk_sel_n) begin
        nbits   = 0;
        framing = 1;
    end

    always @(posedge lnk_sclk) begin
        if (framing && lnk_sel_n === 1'b0) begin
            if (nbits < 24) cap[nbits] = lnk_sdo;
            nbits++;
        end
    end

    always @(posedge lnk_sel_n) begin
        logic [8:0] r;
        if (framing) begin
            framing = 0;
            r = (byte_q.size() > 0) ? byte_q.pop_front() : 9'h000;
            checks++;
            if (nbits != 24) begin
                errors++;
                $display("FAIL R5 clock edges act=%0d exp=24", nbits);
            end
            for (int i = 0; i < 24 && i < nbits; i++) begin
                logic eb;
                eb = stream_bit(r[8], r[7:0], i);
                checks++;
                if (cap[i] !== eb) begin
                    errors++;
                    if (i < 8)       $display("FAIL R2 sync bit %0d act=%b exp=%b", i, cap[i], eb);
                    else if (i < 16) $display("FAIL R3 bit %0d act=%b exp=%b", i, cap[i], eb);
                    else             $display("FAIL R4 bit %0d act=%b exp=%b", i, cap[i], eb);
                end
            end
        end
    end

    task automatic send(input logic isd, input logic [7:0] b, input bit keep);
        in_valid   = 1'b1;
        in_is_data = isd;
        in_byte    = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        if (!keep) in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!(in_ready && exp_q.size() == 0)) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if ({lnk_sel_n, lnk_sclk, lnk_sdo, in_ready, done} !== 5'b11010) begin
            errors++;
            $display("FAIL R1 reset act=%b exp=11010",
                     {lnk_sel_n, lnk_sclk, lnk_sdo, in_ready, done});
        end
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R2 command sync, R3/R4 nibble order
        send(1'b0, 8'h2A, 0); wait_idle();
        // R2 data sync
        send(1'b1, 8'h5C, 0); wait_idle();
        send(1'b0, 8'h00, 0); wait_idle();
        send(1'b1, 8'hFF, 0); wait_idle();
        send(1'b1, 8'hA5, 0); wait_idle();

        // R10: requests offered while busy must be ignored
        send(1'b0, 8'h81, 0);
        repeat (5) @(negedge clk);
        in_valid = 1'b1; in_is_data = 1'b1; in_byte = 8'h3C;
        repeat (6) @(negedge clk);
        in_valid = 1'b0;
        // R10: ignored byte must not reach the link while idle
        wait_idle();
        checks++;
        if (lnk_sel_n !== 1'b1) begin
            errors++;
            $display("FAIL R10 stray frame act=%b exp=1", lnk_sel_n);
        end

        // R11/R9: back-to-back with valid held, accept in the done cycle
        send(1'b1, 8'h12, 1);
        send(1'b0, 8'hDB, 1);
        send(1'b1, 8'h7E, 0);
        wait_idle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule